// File: doc/BRIEF.md
# Bus cycle stretch controller

This block sits beside a CPU core and decides how many bus clock periods each access cycle of the core occupies. At the start of an access the core presents a strobe and a code for the kind of cycle: a program word fetch, a byte or word data read, a byte or word data write, a byte or word stack push, a byte stack pop, or a free cycle. Alongside the strobe come the low address bit, the external bus width mode, and flags for where the access lands: external memory, on-chip RAM, or a region whose chip select is programmed for slow memory, together with that region's two-bit wait setting.

From these the block works out a length in bus cycles. A word access is split in two on a byte-wide external bus. A misaligned word data or stack access costs one extra cycle unless it goes to on-chip RAM, which handles misaligned words in one cycle, or it is already split on the narrow bus. A slow chip-select region adds its wait setting once for every bus cycle of the access. Free cycles always take one period. The block then holds a busy output high for exactly that many clocks and gives a one-clock done pulse when the access is complete. A strobe that arrives while busy is dropped.

Top module: `bus_stretch_ctrl`

## Requirements
- R1: A free cycle (code 0) and any unused code (9 to 15) occupy exactly one bus cycle, whatever the address, bus width, target and chip-select inputs are.
- R2: Byte cycles (code 2 read, 4 write, 6 push, 8 pop) occupy one bus cycle unless the slow chip-select flag is set; bus width, target and address parity have no effect on them.
- R3: Word data and stack cycles (code 3 read, 5 write, 7 push) take two bus cycles when the narrow (8-bit) bus mode is set and the external target flag is set, and one bus cycle when aligned in any other case.
- R4: A program word fetch (code 1) takes two bus cycles on the narrow bus to an external target and one otherwise; address parity has no effect on it.
- R5: A misaligned (odd address) word data or stack cycle adds one bus cycle, except when the on-chip RAM flag is set.
- R6: A misaligned word data or stack cycle on the narrow bus to an external target adds no misalignment cycle, so it stays at two bus cycles.
- R7: When the slow chip-select flag is set, the wait setting N (0 to 3) is added once per bus cycle, giving a length of bus cycles times (1 + N).
- R8: After an accepted strobe, busy is high from the next clock for exactly the computed length, and done is high for the single clock following the last busy clock.
- R9: A strobe while busy is high is ignored: it neither lengthens the current access nor starts another one.
- R10: While reset is active and after its release, busy and done are low until a strobe is accepted.
- R11: A strobe presented in the clock that done is high is accepted, so accesses can follow with no idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Access strobe, sampled when not busy |
| cyc_type | input | 4 | Cycle kind code (see requirements) |
| addr_odd | input | 1 | Low address bit of the access |
| narrow_bus | input | 1 | External data bus is 8 bits wide |
| tgt_ext | input | 1 | Access targets external memory |
| tgt_iram | input | 1 | Access targets on-chip RAM |
| cs_slow | input | 1 | Address lies in a slow chip-select region |
| cs_wait | input | 2 | Wait setting of that region |
| busy | output | 1 | Access in progress, core must hold |
| done | output | 1 | One-clock pulse after the access ends |

## Verification
The end of one access and the acceptance of the next can share a clock: done is high in the very clock that a new strobe is sampled. The bench provokes this by presenting the next strobe in the done clock, and judges it by checking that the first access keeps its full busy length, that the second starts on the following clock with its own expected length, and that no idle clock appears between them. A separate case raises the strobe in mid-access and checks that only one done pulse follows.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

    typedef enum logic [3:0] {
        CYC_FREE   = 4'd0,
        CYC_PROG   = 4'd1,
        CYC_RD8    = 4'd2,
        CYC_RD16   = 4'd3,
        CYC_WR8    = 4'd4,
        CYC_WR16   = 4'd5,
        CYC_PUSH8  = 4'd6,
        CYC_PUSH16 = 4'd7,
        CYC_POP8   = 4'd8
    } cyc_kind_e;

    // Class of an access as far as stretching is concerned
    typedef struct packed {
        logic is_free;   // never stretched
        logic is_prog;   // program word fetch
        logic is_word;   // word data or stack access
        logic is_byte;   // byte data or stack access
    } cyc_class_t;

endpackage

// File: rtl/stretch_decode.sv
module stretch_decode
    import stretch_pkg::*;
(
    input  logic [3:0]  cyc_type,
    output cyc_class_t  cls
);

    always_comb begin
        cls = '0;
        case (cyc_type)
            CYC_PROG:                       cls.is_prog = 1'b1;
            CYC_RD16, CYC_WR16, CYC_PUSH16: cls.is_word = 1'b1;
            CYC_RD8, CYC_WR8, CYC_PUSH8,
            CYC_POP8:                       cls.is_byte = 1'b1;
            default:                        cls.is_free = 1'b1;
        endcase
    end

endmodule

// File: rtl/stretch_count.sv
module stretch_count
    import stretch_pkg::*;
#(
    parameter int WAIT_W = 2,
    parameter int CNT_W  = 4
) (
    input  cyc_class_t         cls,
    input  logic               addr_odd,
    input  logic               narrow_bus,
    input  logic               tgt_ext,
    input  logic               tgt_iram,
    input  logic               cs_slow,
    input  logic [WAIT_W-1:0]  cs_wait,
    output logic [CNT_W-1:0]   total
);

    logic               split;
    logic               mis_pen;
    logic [1:0]         bus_cnt;
    logic [WAIT_W:0]    per_bus;
    logic [CNT_W-1:0]   product;

    always_comb begin
        // A word crossing a byte-wide external bus becomes two byte cycles
        split   = (cls.is_word | cls.is_prog) & narrow_bus & tgt_ext;
        // Misalignment costs a cycle only for data/stack words, not for
        // on-chip RAM, and not when the access is already split
        mis_pen = cls.is_word & addr_odd & ~tgt_iram & ~split;
        bus_cnt = (split | mis_pen) ? 2'd2 : 2'd1;
        per_bus = cs_slow ? ({1'b0, cs_wait} + 1'b1) : {{WAIT_W{1'b0}}, 1'b1};
        product = CNT_W'(bus_cnt) * CNT_W'(per_bus);
        total   = cls.is_free ? CNT_W'(1) : product;
    end

endmodule

// File: rtl/stretch_seq.sv
module stretch_seq #(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  total,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] left;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.left = '0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.left = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

endmodule

// File: rtl/bus_stretch_ctrl.sv
module bus_stretch_ctrl
    import stretch_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        cyc_type,
    input  logic              addr_odd,
    input  logic              narrow_bus,
    input  logic              tgt_ext,
    input  logic              tgt_iram,
    input  logic              cs_slow,
    input  logic [WAIT_W-1:0] cs_wait,
    output logic              busy,
    output logic              done
);

    // Longest access: two bus cycles, each with the largest wait setting
    localparam int MAX_LEN = 2 * (2 ** WAIT_W);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    cyc_class_t       cls;
    logic [CNT_W-1:0] total;

    stretch_decode u_dec (
        .cyc_type (cyc_type),
        .cls      (cls)
    );

    stretch_count #(
        .WAIT_W (WAIT_W),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .cls        (cls),
        .addr_odd   (addr_odd),
        .narrow_bus (narrow_bus),
        .tgt_ext    (tgt_ext),
        .tgt_iram   (tgt_iram),
        .cs_slow    (cs_slow),
        .cs_wait    (cs_wait),
        .total      (total)
    );

    stretch_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .total (total),
        .busy  (busy),
        .done  (done)
    );

endmodule

// File: rtl/stretch_chk.sv
module stretch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] cyc_type,
    input logic       busy,
    input logic       done
);

    // R1: a free or unused code gives one busy clock then done
    p_free_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cyc_type == 4'd0 || cyc_type > 4'd8))
        |=> busy ##1 (done && !busy));

    // R8: done is a single-clock pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows the last busy clock
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9: busy only rises from a strobe taken while idle
    p_rise_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && !$past(busy)));

    // R11: an idle-side strobe, including one in the done clock, is taken
    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: reset leaves the outputs low
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

endmodule

bind bus_stretch_ctrl stretch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cyc_type (cyc_type),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_bus_stretch_ctrl.sv
module tb_bus_stretch_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] cyc_type = 4'd0;
    logic       addr_odd = 1'b0;
    logic       narrow_bus = 1'b0;
    logic       tgt_ext = 1'b0;
    logic       tgt_iram = 1'b0;
    logic       cs_slow = 1'b0;
    logic [1:0] cs_wait = 2'd0;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    string tag_q[$];
    int run_len = 0;
    logic prev_done = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_stretch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_type(cyc_type),
        .addr_odd(addr_odd), .narrow_bus(narrow_bus), .tgt_ext(tgt_ext),
        .tgt_iram(tgt_iram), .cs_slow(cs_slow), .cs_wait(cs_wait),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Monitor: measure each busy run and compare at the done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                check(!prev_done, "R8 done wider than one clock", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(run_len == e, t, run_len, e);
                end
                run_len = 0;
            end
            if (busy) run_len++;
            prev_done = done;
        end
    end

    // Driver: called at a negedge, returns at the negedge where done is seen
    task automatic issue(input logic [3:0] ty, input logic odd, input logic nar,
                         input logic ext, input logic iram, input logic slow,
                         input logic [1:0] n, input int exp, input string tag);
        cyc_type = ty; addr_odd = odd; narrow_bus = nar; tgt_ext = ext;
        tgt_iram = iram; cs_slow = slow; cs_wait = n;
        start = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy in reset", busy, 0);
        check(done == 1'b0, "R10 done in reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R10 idle after reset", busy, 0);

        issue(4'd0, 1, 1, 1, 0, 1, 2'd3, 1, "R1 free with slow cs");
        @(negedge clk);
        issue(4'd12, 1, 1, 1, 0, 1, 2'd2, 1, "R1 unused code");
        @(negedge clk);
        issue(4'd2, 1, 1, 1, 0, 0, 2'd3, 1, "R2 byte read narrow ext");
        @(negedge clk);
        issue(4'd6, 1, 1, 1, 0, 0, 2'd0, 1, "R2 byte push odd narrow");
        @(negedge clk);
        issue(4'd4, 0, 0, 1, 0, 1, 2'd2, 3, "R2 R7 byte write slow n2");
        @(negedge clk);
        issue(4'd3, 0, 1, 1, 0, 0, 2'd0, 2, "R3 word read narrow ext");
        @(negedge clk);
        issue(4'd7, 0, 0, 1, 0, 0, 2'd0, 1, "R3 word push wide ext");
        @(negedge clk);
        issue(4'd3, 0, 1, 0, 1, 0, 2'd0, 1, "R3 word read narrow iram");
        @(negedge clk);
        issue(4'd1, 0, 1, 1, 0, 0, 2'd0, 2, "R4 fetch narrow ext");
        @(negedge clk);
        issue(4'd1, 1, 1, 1, 0, 0, 2'd0, 2, "R4 fetch odd narrow ext");
        @(negedge clk);
        issue(4'd1, 1, 0, 1, 0, 0, 2'd0, 1, "R4 fetch odd wide");
        @(negedge clk);
        issue(4'd5, 1, 0, 1, 0, 0, 2'd0, 2, "R5 word write odd wide ext");
        @(negedge clk);
        issue(4'd3, 1, 0, 0, 1, 0, 2'd0, 1, "R5 word read odd iram");
        @(negedge clk);
        issue(4'd7, 1, 1, 1, 0, 0, 2'd0, 2, "R6 word push odd narrow ext");
        @(negedge clk);
        issue(4'd3, 1, 1, 1, 0, 1, 2'd3, 8, "R6 R7 word read odd narrow slow n3");
        @(negedge clk);
        issue(4'd5, 1, 0, 1, 0, 1, 2'd1, 4, "R5 R7 word write odd slow n1");
        @(negedge clk);
        issue(4'd8, 0, 0, 0, 0, 1, 2'd3, 4, "R7 byte pop slow n3");
        @(negedge clk);

        // R11: back-to-back, second strobe in the done clock
        issue(4'd3, 0, 1, 1, 0, 0, 2'd0, 2, "R11 first of pair");
        issue(4'd4, 0, 0, 0, 0, 1, 2'd1, 2, "R11 second of pair");
        @(negedge clk);

        // R9: strobe in mid-access is dropped
        cyc_type = 4'd3; addr_odd = 1'b1; narrow_bus = 1'b1; tgt_ext = 1'b1;
        tgt_iram = 1'b0; cs_slow = 1'b1; cs_wait = 2'd3;
        start = 1'b1;
        exp_q.push_back(8);
        tag_q.push_back("R9 length kept with mid strobe");
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        cyc_type = 4'd0; cs_slow = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9 no second access", busy, 0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule